// File: doc/BRIEF.md
# DMA Channel Request Front End

This block decides when one DMA channel may start its next transfer. A stored configuration word picks where transfer requests come from. The choices are an external request pin, a self-generated request that is always present, or a request line from a peripheral routed through an extended selector. When the pin is the source, the block sees a request in one of four ways: while the pin is low, while it is high, on a falling edge, or on a rising edge. The block turns accepted requests into single-cycle transfer-start strobes. In cycle-steal style each strobe waits for the previous transfer's done strobe. In burst style, strobes follow one another on every clock.

The channel's datapath pulses `cfg_wr` to load new settings. It raises `chan_en` to run the channel and drives `count_left` high while transfers remain. The datapath answers each transfer with `xfer_done`. Two parameters state whether this channel may use the pin source and the extended peripheral selector. On a channel that lacks either capability, the matching encoding counts as prohibited.

Top module: `dma_req_front`

## Requirements
- R1: After reset all stored fields are 0, which selects the pin source with low-level detect in cycle-steal style. While `chan_en` is 0, `xfer_start` stays 0.
- R2: With source code 4'b0100 (self request) and style bit 0 (cycle steal), one strobe is issued. No further strobe comes until a `xfer_done` pulse arrives, and the next strobe follows in the cycle after that pulse.
- R3: With self request and style bit 1 (burst), `xfer_start` is high on every cycle while `count_left` is 1. It drops in the first cycle that `count_left` is 0.
- R4: With source code 4'b0000 (pin) and detect code 2'b10 (high level), a strobe appears in the second cycle after the pin rises. That delay comes from the two synchronizer stages.
- R5: With detect code 2'b00 (low level), a synchronized low pin requests a transfer. A high pin does not.
- R6: With detect code 2'b11 (rising edge), each rising edge latches one pending request. That request produces exactly one strobe, three cycles after the pin change. A pin that stays high requests nothing more.
- R7: With detect code 2'b01 (falling edge), each falling edge produces exactly one strobe, three cycles after the pin change.
- R8: With source code 4'b1000 (peripheral through the extended selector), `periph_req` requests transfers. Cycle-steal style is used even when the style bit is 1.
- R9: Any source code other than 4'b0000, 4'b0100 or 4'b1000 produces no strobe.
- R10: A source code written while `chan_en` is 1 is discarded and the old source stays in force. A source code written while `chan_en` is 0 takes effect.
- R11: The detect code has no effect when the source is self request or peripheral.
- R12: Dropping `chan_en` stops strobes in that same cycle and discards a latched edge request.
- R13: On a channel built with `EXT_CAPABLE=0` and `SEL_CAPABLE=0`, the pin and peripheral source codes behave as prohibited, and self request works unchanged.
- R14: With pin source, a level detect code and style bit 1, strobes repeat on every cycle until the synchronized pin leaves the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Loads the three configuration fields below |
| cfg_src | input | 4 | Source code to store |
| cfg_det | input | 2 | Pin detect code to store |
| cfg_burst | input | 1 | Style bit to store: 0 cycle steal, 1 burst |
| chan_en | input | 1 | Channel enable |
| req_pin | input | 1 | Asynchronous external request pin |
| periph_req | input | 1 | Peripheral request, synchronous |
| count_left | input | 1 | High while transfers remain |
| xfer_done | input | 1 | One-cycle pulse when a transfer finishes |
| xfer_start | output | 1 | One-cycle transfer-start strobe |

## Verification
The bench drives the pin with a held level, a single rising step and a single falling step, under each of the four detect codes. This separates level behaviour (the strobe lasts as long as the level) from edge behaviour (one strobe per change). It also pins down the two- and three-cycle latencies. The self request is run in both styles, which tells back-to-back issue apart from issue gated by the done strobe. The peripheral line is run with the burst bit set, to show that cycle-steal style is forced. Source rewrites are made while the channel is enabled and while it is disabled, to show the lock. A second instance without pin or selector capability receives the same stimulus, so every pin and peripheral pattern also checks that those codes are refused on that channel.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  localparam logic [3:0] SRC_PIN    = 4'b0000;
  localparam logic [3:0] SRC_AUTO   = 4'b0100;
  localparam logic [3:0] SRC_PERIPH = 4'b1000;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_HIGH = 2'b10,
    DET_RISE = 2'b11
  } det_e;

  typedef enum logic [1:0] {
    K_PIN,
    K_AUTO,
    K_PERIPH,
    K_NONE
  } kind_e;

  // Decode a source code, refusing capabilities this channel lacks.
  function automatic kind_e src_kind(input logic [3:0] src, input bit ext_ok,
                                     input bit sel_ok);
    kind_e k;
    if (src == SRC_AUTO)                 k = K_AUTO;
    else if (src == SRC_PIN && ext_ok)   k = K_PIN;
    else if (src == SRC_PERIPH && sel_ok) k = K_PERIPH;
    else                                 k = K_NONE;
    return k;
  endfunction

  function automatic bit det_is_edge(input det_e d);
    return d[0];
  endfunction

  // Level match: bit 1 of the code gives the active level.
  function automatic bit level_hit(input det_e d, input logic s);
    return (s == d[1]);
  endfunction

  function automatic bit edge_hit(input det_e d, input logic cur, input logic prev);
    bit r;
    case (d)
      DET_RISE: r = cur && !prev;
      DET_FALL: r = !cur && prev;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Burst issue only for self request or a level-detected pin.
  function automatic bit burst_allowed(input kind_e k, input det_e d, input logic b);
    bit r;
    case (k)
      K_AUTO:  r = b;
      K_PIN:   r = b && !det_is_edge(d);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dreq_cfg_reg.sv
module dreq_cfg_reg
  import dreq_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SRC_W-1:0] src_in,
  input  logic [1:0]       det_in,
  input  logic             burst_in,
  input  logic             chan_en,
  output logic [SRC_W-1:0] src_q,
  output det_e             det_q,
  output logic             burst_q
);

  logic src_load;
  assign src_load = wr && !chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      det_q   <= DET_LOW;
      burst_q <= 1'b0;
    end else begin
      if (src_load) src_q <= src_in;
      if (wr) begin
        det_q   <= det_e'(det_in);
        burst_q <= burst_in;
      end
    end
  end

endmodule

// File: rtl/dreq_pin_detect.sv
module dreq_pin_detect
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  det_e det,
  input  logic arm,
  input  logic take,
  output logic hit,
  output logic pend,
  output logic edge_seen
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;
  logic          s_now;
  logic          s_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], pin};
      end
    end
  endgenerate

  assign s_now = chain[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= s_now;
  end

  assign edge_seen = edge_hit(det, s_now, s_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (!arm) pend <= 1'b0;
    else           pend <= edge_seen || (pend && !take);
  end

  assign hit = arm && (det_is_edge(det) ? pend : level_hit(det, s_now));

endmodule

// File: rtl/dreq_issue.sv
module dreq_issue (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req,
  input  logic count_left,
  input  logic done,
  input  logic burst_eff,
  output logic start,
  output logic busy
);

  assign start = en && !busy && req && count_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy <= 1'b0;
    else if (!en)  busy <= 1'b0;
    else if (busy) busy <= !done;
    else           busy <= start && !burst_eff;
  end

endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
  import dreq_pkg::*;
#(
  parameter bit EXT_CAPABLE = 1'b1,
  parameter bit SEL_CAPABLE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_src,
  input  logic [1:0] cfg_det,
  input  logic       cfg_burst,
  input  logic       chan_en,
  input  logic       req_pin,
  input  logic       periph_req,
  input  logic       count_left,
  input  logic       xfer_done,
  output logic       xfer_start
);

  logic [3:0] src_q;
  det_e       det_q;
  logic       burst_q;
  kind_e      kind;
  logic       pin_arm;
  logic       pin_hit;
  logic       pend;
  logic       edge_seen;
  logic       req_now;
  logic       burst_eff;
  logic       busy;
  logic       src_illegal;

  dreq_cfg_reg #(.SRC_W(4)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .src_in   (cfg_src),
    .det_in   (cfg_det),
    .burst_in (cfg_burst),
    .chan_en  (chan_en),
    .src_q    (src_q),
    .det_q    (det_q),
    .burst_q  (burst_q)
  );

  assign kind        = src_kind(src_q, EXT_CAPABLE, SEL_CAPABLE);
  assign src_illegal = (kind == K_NONE);
  assign pin_arm     = chan_en && (kind == K_PIN);

  dreq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (req_pin),
    .det       (det_q),
    .arm       (pin_arm),
    .take      (xfer_start),
    .hit       (pin_hit),
    .pend      (pend),
    .edge_seen (edge_seen)
  );

  always_comb begin
    case (kind)
      K_PIN:    req_now = pin_hit;
      K_AUTO:   req_now = 1'b1;
      K_PERIPH: req_now = periph_req;
      default:  req_now = 1'b0;
    endcase
  end

  assign burst_eff = burst_allowed(kind, det_q, burst_q);

  dreq_issue u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (chan_en),
    .req        (req_now),
    .count_left (count_left),
    .done       (xfer_done),
    .burst_eff  (burst_eff),
    .start      (xfer_start),
    .busy       (busy)
  );

endmodule

// File: rtl/dreq_front_chk.sv
module dreq_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_en,
  input logic       count_left,
  input logic       xfer_start,
  input logic [3:0] src_q,
  input logic       src_illegal,
  input logic       burst_eff,
  input logic       pend
);

  // R12
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !xfer_start);

  // R2
  steal_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !burst_eff) |=> !xfer_start);

  // R9
  bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_illegal |-> !xfer_start);

  // R3
  count_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_left |-> !xfer_start);

  // R10
  src_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && $past(chan_en)) |-> $stable(src_q));

  // R12
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !pend);

endmodule

bind dma_req_front dreq_front_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_en     (chan_en),
  .count_left  (count_left),
  .xfer_start  (xfer_start),
  .src_q       (src_q),
  .src_illegal (src_illegal),
  .burst_eff   (burst_eff),
  .pend        (pend)
);

// File: tb/sim_dma_req_front.sv
module sim_dma_req_front;

  localparam int PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_src = 4'd0;
  logic [1:0] cfg_det = 2'd0;
  logic       cfg_burst = 1'b0;
  logic       chan_en = 1'b0;
  logic       req_pin = 1'b0;
  logic       periph_req = 1'b0;
  logic       count_left = 1'b1;
  logic       xfer_done = 1'b0;
  logic       st0;
  logic       st1;

  always #(PER/2) clk = ~clk;

  dma_req_front u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src(cfg_src),
    .cfg_det(cfg_det), .cfg_burst(cfg_burst), .chan_en(chan_en),
    .req_pin(req_pin), .periph_req(periph_req), .count_left(count_left),
    .xfer_done(xfer_done), .xfer_start(st0)
  );

  dma_req_front #(.EXT_CAPABLE(1'b0), .SEL_CAPABLE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src(cfg_src),
    .cfg_det(cfg_det), .cfg_burst(cfg_burst), .chan_en(chan_en),
    .req_pin(req_pin), .periph_req(periph_req), .count_left(count_left),
    .xfer_done(xfer_done), .xfer_start(st1)
  );

  typedef struct {
    bit    care;
    bit    e0;
    bit    e1;
    string tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Driver: push the expectation for the current cycle, then advance.
  task automatic tick(input bit care, input bit e0, input bit e1, input string tag);
    item_t it;
    it.care = care; it.e0 = e0; it.e1 = e1; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] s, input logic [1:0] d, input bit b);
    cfg_wr = 1'b1; cfg_src = s; cfg_det = d; cfg_burst = b;
    tick(1, 0, 0, "R1");
    cfg_wr = 1'b0;
  endtask

  // Monitor: compare each item just before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #(PER/2 - 1);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.care) begin
          n_cmp++;
          if (st0 !== it.e0) begin
            n_bad++;
            $display("FAIL %s: u0 xfer_start=%0b expected=%0b at %0t", it.tag, st0, it.e0, $time);
          end
          if (st1 !== it.e1) begin
            n_bad++;
            $display("FAIL R13 (%s): u1 xfer_start=%0b expected=%0b at %0t", it.tag, st1, it.e1, $time);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, disabled channel stays quiet
    tick(1, 0, 0, "R1");
    tick(1, 0, 0, "R1");

    // R2: self request, cycle steal
    write_cfg(4'b0100, 2'b00, 1'b0);
    chan_en = 1'b1;
    tick(1, 1, 1, "R2");
    tick(1, 0, 0, "R2");
    tick(1, 0, 0, "R2");
    xfer_done = 1'b1;
    tick(1, 0, 0, "R2");
    xfer_done = 1'b0;
    tick(1, 1, 1, "R2");
    chan_en = 1'b0;
    tick(1, 0, 0, "R12");

    // R3: self request, burst, halted by count
    write_cfg(4'b0100, 2'b00, 1'b1);
    chan_en = 1'b1;
    tick(1, 1, 1, "R3");
    tick(1, 1, 1, "R3");
    tick(1, 1, 1, "R3");
    count_left = 1'b0;
    tick(1, 0, 0, "R3");
    count_left = 1'b1;
    chan_en = 1'b0;
    tick(1, 0, 0, "R3");

    // R11: detect code irrelevant for self request
    write_cfg(4'b0100, 2'b10, 1'b1);
    chan_en = 1'b1;
    tick(1, 1, 1, "R11");
    tick(1, 1, 1, "R11");
    chan_en = 1'b0;
    tick(1, 0, 0, "R11");

    // R4: pin, high level, cycle steal
    write_cfg(4'b0000, 2'b10, 1'b0);
    chan_en = 1'b1; req_pin = 1'b1;
    tick(1, 0, 0, "R4");
    tick(1, 0, 0, "R4");
    tick(1, 1, 0, "R4");
    req_pin = 1'b0;
    tick(1, 0, 0, "R4");
    tick(1, 0, 0, "R4");
    tick(1, 0, 0, "R4");
    xfer_done = 1'b1;
    tick(1, 0, 0, "R4");
    xfer_done = 1'b0;
    tick(1, 0, 0, "R4");
    chan_en = 1'b0;
    tick(1, 0, 0, "R4");

    // R5: pin, low level (pin low already synchronized)
    write_cfg(4'b0000, 2'b00, 1'b0);
    chan_en = 1'b1;
    tick(1, 1, 0, "R5");
    req_pin = 1'b1;
    tick(1, 0, 0, "R5");
    tick(1, 0, 0, "R5");
    tick(1, 0, 0, "R5");
    xfer_done = 1'b1;
    tick(1, 0, 0, "R5");
    xfer_done = 1'b0;
    tick(1, 0, 0, "R5");
    chan_en = 1'b0;
    tick(1, 0, 0, "R5");

    // R14: pin, high level, burst
    req_pin = 1'b0;
    write_cfg(4'b0000, 2'b10, 1'b1);
    tick(0, 0, 0, "R14");
    chan_en = 1'b1; req_pin = 1'b1;
    tick(1, 0, 0, "R14");
    tick(1, 0, 0, "R14");
    tick(1, 1, 0, "R14");
    tick(1, 1, 0, "R14");
    req_pin = 1'b0;
    tick(1, 1, 0, "R14");
    tick(1, 1, 0, "R14");
    tick(1, 0, 0, "R14");
    chan_en = 1'b0;
    tick(1, 0, 0, "R14");

    // R6: rising edge, one strobe per edge even with burst bit
    write_cfg(4'b0000, 2'b11, 1'b1);
    chan_en = 1'b1;
    tick(1, 0, 0, "R6");
    req_pin = 1'b1;
    tick(1, 0, 0, "R6");
    tick(1, 0, 0, "R6");
    tick(1, 0, 0, "R6");
    tick(1, 1, 0, "R6");
    tick(1, 0, 0, "R6");
    xfer_done = 1'b1;
    tick(1, 0, 0, "R6");
    xfer_done = 1'b0;
    tick(1, 0, 0, "R6");
    tick(1, 0, 0, "R6");
    chan_en = 1'b0;
    tick(1, 0, 0, "R6");

    // R7: falling edge
    write_cfg(4'b0000, 2'b01, 1'b0);
    chan_en = 1'b1;
    tick(1, 0, 0, "R7");
    req_pin = 1'b0;
    tick(1, 0, 0, "R7");
    tick(1, 0, 0, "R7");
    tick(1, 0, 0, "R7");
    tick(1, 1, 0, "R7");
    tick(1, 0, 0, "R7");
    xfer_done = 1'b1;
    tick(1, 0, 0, "R7");
    xfer_done = 1'b0;
    req_pin = 1'b1;
    tick(1, 0, 0, "R7");
    tick(1, 0, 0, "R7");
    tick(1, 0, 0, "R7");
    // R12: latched falling edge discarded by disable
    req_pin = 1'b0;
    tick(1, 0, 0, "R12");
    tick(1, 0, 0, "R12");
    tick(1, 0, 0, "R12");
    chan_en = 1'b0;
    tick(1, 0, 0, "R12");
    chan_en = 1'b1;
    tick(1, 0, 0, "R12");
    tick(1, 0, 0, "R12");
    chan_en = 1'b0;
    tick(1, 0, 0, "R12");

    // R8: peripheral source, burst bit set, cycle steal forced
    write_cfg(4'b1000, 2'b10, 1'b1);
    periph_req = 1'b1; chan_en = 1'b1;
    tick(1, 1, 0, "R8");
    tick(1, 0, 0, "R8");
    tick(1, 0, 0, "R8");
    xfer_done = 1'b1;
    tick(1, 0, 0, "R8");
    xfer_done = 1'b0;
    tick(1, 1, 0, "R8");
    chan_en = 1'b0;
    tick(1, 0, 0, "R8");

    // R9: prohibited code
    write_cfg(4'b0010, 2'b00, 1'b0);
    chan_en = 1'b1;
    tick(1, 0, 0, "R9");
    tick(1, 0, 0, "R9");
    // R10: source write while enabled is discarded
    cfg_wr = 1'b1; cfg_src = 4'b0100;
    tick(1, 0, 0, "R10");
    cfg_wr = 1'b0;
    tick(1, 0, 0, "R10");
    tick(1, 0, 0, "R10");
    chan_en = 1'b0;
    write_cfg(4'b0100, 2'b00, 1'b0);
    chan_en = 1'b1;
    tick(1, 1, 1, "R10");
    tick(1, 0, 0, "R10");
    chan_en = 1'b0; periph_req = 1'b0;
    tick(1, 0, 0, "R10");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule